// File: doc/BRIEF.md
# Floating-Point Control and Status Registers

This block keeps the two software-visible registers of a floating-point unit: a control word and a status word. It sits on a simple auxiliary-register read/write bus. The control word holds two trap-enable bits and a two-bit rounding-mode field. The rounding mode is driven straight to the arithmetic datapath. The status word holds five sticky exception flags.

Each cycle the datapath reports exceptions on a five-bit event input. For the invalid-operation and divide-by-zero exceptions, the matching trap-enable bit decides the outcome. When the enable bit is clear, the exception is recorded as a sticky flag. When it is set, the block pulses a trap request instead. Software can overwrite the flags only with a status write whose most significant data bit is 1. That qualifier bit is never stored and always reads back as zero.

Reads are registered. The read data appears one cycle after the read strobe and shows the register contents as they stood before any write on the same clock edge. Read data is zero in every other cycle.

Top module: `fpcsr_top`

## Requirements
- R1: Reset, a synchronous active-high input, puts the control word at 0x00000100 and the status flags at 0. It drives rounding mode 01 and trap request 0.
- R2: A write to the control address (0x300) stores data bit 0 (invalid trap enable), data bit 1 (divide-by-zero trap enable) and data bits [9:8] (rounding mode). The rounding-mode output shows the new field after that clock edge. The encoding is 00 toward zero, 01 nearest, 10 toward plus infinity, 11 toward minus infinity. All other control bits read as 0.
- R3: A write to the status address (0x301) with data bit 31 set replaces the flags with data bits [4:0]. Bit 0 is invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow and bit 4 inexact.
- R4: A status write with data bit 31 clear leaves the flags unchanged.
- R5: Status bits [31:5] always read as 0, including the write-qualifier bit 31.
- R6: An event bit whose exception is not trap-enabled sets the matching flag. Flags stay set until a qualified status write clears them.
- R7: When a qualified status write and datapath events occur in the same cycle, the written value is applied and the events are ORed on top of it.
- R8: An invalid or divide-by-zero event whose enable bit is set raises the trap request for exactly the one cycle after the event cycle. That event does not set its flag.
- R9: Overflow, underflow and inexact events never raise the trap request.
- R10: A read of any address other than 0x300 and 0x301 returns 0. Read data is 0 in any cycle not following a read. Reads change no state.
- R11: Read data appears in the cycle after the read strobe and reflects the register value before a write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 12 | Auxiliary register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fp_evt | input | 5 | Per-cycle exception events from the datapath |
| rnd_mode | output | 2 | Rounding mode to the datapath |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench builds the block with its default parameters. These are a 12-bit address, a 32-bit data word, the control word at 0x300 and the status word at 0x301, with the write qualifier at bit 31. This lets the bench reach the qualifier bit, full-width writes of all ones, and the neighbouring address 0x302 as an unmapped location. The bench also covers same-edge read/write and write/event collisions, a trap-enable pattern that enables only one of the two trapping exceptions, and a reset applied in the middle of a run.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int NUM_TRAPS = 2;
  localparam int RM_W      = 2;

  typedef enum logic [RM_W-1:0] {
    RND_ZERO    = 2'b00,
    RND_NEAREST = 2'b01,
    RND_POS_INF = 2'b10,
    RND_NEG_INF = 2'b11
  } rnd_t;

  localparam int FLG_INVALID  = 0;
  localparam int FLG_DIVZERO  = 1;
  localparam int FLG_OVERFLOW = 2;
  localparam int FLG_UNDERFL  = 3;
  localparam int FLG_INEXACT  = 4;
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int RM_LSB    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h300
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_TRAPS-1:0] wr_en_bits,
  input  logic [RM_W-1:0]      wr_rm,
  output logic [NUM_TRAPS-1:0] trap_en,
  output logic [RM_W-1:0]      rnd_mode,
  output logic [DATA_W-1:0]    ctrl_word
);
  logic ctrl_hit;
  logic [NUM_TRAPS-1:0] en_q;
  logic [RM_W-1:0] rm_q;

  assign ctrl_hit = wr_en && (addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      rm_q <= RND_NEAREST;
    end else if (ctrl_hit) begin
      en_q <= wr_en_bits;
      rm_q <= wr_rm;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[NUM_TRAPS-1:0] = en_q;
    ctrl_word[RM_LSB +: RM_W] = rm_q;
  end

  assign trap_en  = en_q;
  assign rnd_mode = rm_q;

  logic chk_en;
  always_ff @(posedge clk) begin
    if (rst) chk_en <= 1'b0;
    else     chk_en <= 1'b1;
  end

  // R2: the rounding field moves only on a control write
  assert_rm_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !ctrl_hit) |=> $stable(rnd_mode));
  // R2: the trap enables move only on a control write
  assert_en_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !ctrl_hit) |=> $stable(trap_en));
endmodule

// File: rtl/fpcsr_flags.sv
module fpcsr_flags
  import fpcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WE_BIT = 31,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h301
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_qual,
  input  logic [NUM_FLAGS-1:0] wr_flags,
  input  logic [NUM_FLAGS-1:0] evt,
  input  logic [NUM_TRAPS-1:0] trap_en,
  output logic [DATA_W-1:0]    stat_word
);
  logic [NUM_FLAGS-1:0] flags_q, rec_mask, base;
  logic stat_hit, load;

  assign stat_hit = wr_en && (addr == STAT_ADDR);
  assign load     = stat_hit && wr_qual;

  // trap-enabled exceptions are routed to the trap, not recorded
  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_mask
      if (i < NUM_TRAPS) begin : g_trapable
        assign rec_mask[i] = ~trap_en[i];
      end else begin : g_plain
        assign rec_mask[i] = 1'b1;
      end
    end
  endgenerate

  assign base = load ? wr_flags : flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= base | (evt & rec_mask);
  end

  assign stat_word = DATA_W'(flags_q);

  logic chk_en;
  always_ff @(posedge clk) begin
    if (rst) chk_en <= 1'b0;
    else     chk_en <= 1'b1;
  end

  // R6: without a qualified write no flag ever drops
  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !load) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R4: unqualified status write with no events changes nothing
  assert_unqualified_write_R4: assert property (@(posedge clk) disable iff (rst)
    (chk_en && stat_hit && !wr_qual && evt == '0) |=> $stable(flags_q));
  // R8: an enabled invalid event does not record its flag
  assert_enabled_inv_unrecorded_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !load && trap_en[FLG_INVALID]) |=> $stable(flags_q[FLG_INVALID]));
  // R7: write then OR of events lands in the same edge
  assert_write_event_merge_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_en && load && trap_en == '0) |=> (flags_q == ($past(wr_flags) | $past(evt))));
endmodule

// File: rtl/fpcsr_trap.sv
module fpcsr_trap
  import fpcsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TRAPS-1:0] evt,
  input  logic [NUM_TRAPS-1:0] trap_en,
  output logic                 trap_req
);
  logic [NUM_TRAPS-1:0] cause;

  generate
    for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_cause
      assign cause[i] = evt[i] & trap_en[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) trap_req <= 1'b0;
    else     trap_req <= |cause;
  end
endmodule

// File: rtl/fpcsr_rdport.sv
module fpcsr_rdport #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h300,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h301
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_en) begin
      if (addr == CTRL_ADDR)      sel = ctrl_word;
      else if (addr == STAT_ADDR) sel = stat_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  logic chk_en;
  always_ff @(posedge clk) begin
    if (rst) chk_en <= 1'b0;
    else     chk_en <= 1'b1;
  end

  // R10: idle bus gives zero read data
  assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !rd_en) |=> (rdata == '0));
  // R5: the write-qualifier position never reads back as one
  assert_qual_bit_zero_R5: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> !rdata[DATA_W-1]);
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WE_BIT = 31,
  parameter int RM_LSB = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h300,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h301
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_FLAGS-1:0] fp_evt,
  output logic [RM_W-1:0]   rnd_mode,
  output logic              trap_req
);
  logic [NUM_TRAPS-1:0] trap_en;
  logic [DATA_W-1:0]    ctrl_word, stat_word;

  fpcsr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RM_LSB(RM_LSB), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .addr(bus_addr),
    .wr_en_bits(bus_wdata[NUM_TRAPS-1:0]), .wr_rm(bus_wdata[RM_LSB +: RM_W]),
    .trap_en(trap_en), .rnd_mode(rnd_mode), .ctrl_word(ctrl_word)
  );

  fpcsr_flags #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_BIT(WE_BIT), .STAT_ADDR(STAT_ADDR)
  ) u_flags (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .addr(bus_addr),
    .wr_qual(bus_wdata[WE_BIT]), .wr_flags(bus_wdata[NUM_FLAGS-1:0]),
    .evt(fp_evt), .trap_en(trap_en), .stat_word(stat_word)
  );

  fpcsr_trap u_trap (
    .clk(clk), .rst(rst), .evt(fp_evt[NUM_TRAPS-1:0]), .trap_en(trap_en),
    .trap_req(trap_req)
  );

  fpcsr_rdport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .addr(bus_addr),
    .ctrl_word(ctrl_word), .stat_word(stat_word), .rdata(bus_rdata)
  );

  logic chk_en;
  always_ff @(posedge clk) begin
    if (rst) chk_en <= 1'b0;
    else     chk_en <= 1'b1;
  end

  // R9: non-trapping exceptions alone never request a trap
  assert_no_trap_on_plain_R9: assert property (@(posedge clk) disable iff (rst)
    (chk_en && fp_evt[NUM_TRAPS-1:0] == '0) |=> !trap_req);
  // R8: trap request never lasts two cycles without a fresh trapping event
  assert_trap_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_en && trap_req && fp_evt[NUM_TRAPS-1:0] == '0) |=> !trap_req);
endmodule

// File: tb/test_fpcsr_top.sv
`timescale 1ns/1ps
module test_fpcsr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  fp_evt = '0;
  logic [1:0]  rnd_mode;
  logic        trap_req;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpcsr_top i_fpcsr_top (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fp_evt(fp_evt), .rnd_mode(rnd_mode), .trap_req(trap_req)
  );

  // fields: req, wr, rd, addr, wdata, evt | exp rdata, exp rnd, exp trap
  localparam int NV = 28;
  localparam logic [89:0] VEC [NV] = '{
    {4'd1, 1'b0,1'b1,12'h300,32'h0000_0000,5'h00, 32'h0000_0100,2'd1,1'b0}, // R1
    {4'd1, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_0000,2'd1,1'b0}, // R1
    {4'd2, 1'b1,1'b0,12'h300,32'hFFFF_FEFC,5'h00, 32'h0000_0000,2'd2,1'b0}, // R2
    {4'd2, 1'b0,1'b1,12'h300,32'h0000_0000,5'h00, 32'h0000_0200,2'd2,1'b0}, // R2
    {4'd2, 1'b1,1'b0,12'h300,32'h0000_0300,5'h00, 32'h0000_0000,2'd3,1'b0}, // R2
    {4'd2, 1'b1,1'b0,12'h300,32'h0000_0000,5'h00, 32'h0000_0000,2'd0,1'b0}, // R2
    {4'd6, 1'b0,1'b0,12'h000,32'h0000_0000,5'h1F, 32'h0000_0000,2'd0,1'b0}, // R6
    {4'd6, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_001F,2'd0,1'b0}, // R6
    {4'd4, 1'b1,1'b0,12'h301,32'h0000_0000,5'h00, 32'h0000_0000,2'd0,1'b0}, // R4
    {4'd4, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_001F,2'd0,1'b0}, // R4
    {4'd3, 1'b1,1'b0,12'h301,32'h8000_0005,5'h00, 32'h0000_0000,2'd0,1'b0}, // R3
    {4'd3, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_0005,2'd0,1'b0}, // R3
    {4'd6, 1'b0,1'b0,12'h000,32'h0000_0000,5'h08, 32'h0000_0000,2'd0,1'b0}, // R6
    {4'd7, 1'b1,1'b0,12'h301,32'h8000_0000,5'h10, 32'h0000_0000,2'd0,1'b0}, // R7
    {4'd7, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_0010,2'd0,1'b0}, // R7
    {4'd2, 1'b1,1'b0,12'h300,32'h0000_0103,5'h00, 32'h0000_0000,2'd1,1'b0}, // R2
    {4'd8, 1'b0,1'b0,12'h000,32'h0000_0000,5'h03, 32'h0000_0000,2'd1,1'b1}, // R8
    {4'd8, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_0010,2'd1,1'b0}, // R8
    {4'd9, 1'b0,1'b0,12'h000,32'h0000_0000,5'h1C, 32'h0000_0000,2'd1,1'b0}, // R9
    {4'd10,1'b0,1'b1,12'h302,32'h0000_0000,5'h00, 32'h0000_0000,2'd1,1'b0}, // R10
    {4'd10,1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_001C,2'd1,1'b0}, // R10
    {4'd11,1'b1,1'b1,12'h300,32'h0000_0101,5'h00, 32'h0000_0103,2'd1,1'b0}, // R11
    {4'd11,1'b0,1'b1,12'h300,32'h0000_0000,5'h00, 32'h0000_0101,2'd1,1'b0}, // R11
    {4'd8, 1'b0,1'b0,12'h000,32'h0000_0000,5'h03, 32'h0000_0000,2'd1,1'b1}, // R8
    {4'd8, 1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_001E,2'd1,1'b0}, // R8
    {4'd10,1'b1,1'b0,12'h302,32'hFFFF_FFFF,5'h00, 32'h0000_0000,2'd1,1'b0}, // R10
    {4'd10,1'b0,1'b1,12'h300,32'h0000_0000,5'h00, 32'h0000_0101,2'd1,1'b0}, // R10
    {4'd10,1'b0,1'b1,12'h301,32'h0000_0000,5'h00, 32'h0000_001E,2'd1,1'b0}  // R10
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic wr, input logic rd, input logic [11:0] a,
                     input logic [31:0] d, input logic [4:0] e);
    bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d; fp_evt = e;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs right after reset
    check(1, "rnd after reset", 32'(rnd_mode), 32'd1);
    check(1, "trap after reset", 32'(trap_req), 32'd0);
    check(10, "rdata idle", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][85], VEC[i][84], VEC[i][83:72], VEC[i][71:40], VEC[i][39:35]);
      check(int'(VEC[i][89:86]), $sformatf("vec %0d rdata", i), bus_rdata, VEC[i][34:3]);
      check(int'(VEC[i][89:86]), $sformatf("vec %0d rnd", i), 32'(rnd_mode), 32'(VEC[i][2:1]));
      check(int'(VEC[i][89:86]), $sformatf("vec %0d trap", i), 32'(trap_req), 32'(VEC[i][0]));
    end

    // R5: all-ones qualified status write, only flag bits read back
    cyc(1'b1, 1'b0, 12'h301, 32'hFFFF_FFFF, 5'h00);
    cyc(1'b0, 1'b1, 12'h301, 32'h0, 5'h00);
    check(5, "status upper bits", bus_rdata, 32'h0000_001F);

    // R1: reset in the middle of a run restores defaults
    cyc(1'b1, 1'b0, 12'h300, 32'h0000_0203, 5'h00);
    rst = 1'b1;
    cyc(1'b0, 1'b0, 12'h000, 32'h0, 5'h00);
    cyc(1'b0, 1'b0, 12'h000, 32'h0, 5'h03);
    rst = 1'b0;
    check(1, "rnd after mid reset", 32'(rnd_mode), 32'd1);
    check(1, "trap after mid reset", 32'(trap_req), 32'd0);
    cyc(1'b0, 1'b1, 12'h300, 32'h0, 5'h00);
    check(1, "ctrl after mid reset", bus_rdata, 32'h0000_0100);
    cyc(1'b0, 1'b1, 12'h301, 32'h0, 5'h00);
    check(1, "status after mid reset", bus_rdata, 32'h0);
    cyc(1'b0, 1'b0, 12'h000, 32'h0, 5'h00);
    check(10, "rdata idle at end", bus_rdata, 32'h0);

    finish_run();
  end
endmodule